// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a table of selector counters decide which one to trust. The first component is a per-address table of 2-bit counters. The second component is a global predictor. It forms its table index by XOR-ing the branch address with a register that holds the most recent branch outcomes.

The selector is itself a second-level table. Its index combines the branch address with the same outcome history the global component uses. Because of this, the choice between components can differ for one branch depending on the path that led to it. The selector takes its history from the global component's register and keeps no history register of its own.

The fetch side presents a PC and reads back, in the same cycle, the final direction, both component directions and the selector's choice. The execute side reports each resolved branch in program order with its PC and actual outcome. One cycle after a resolve, the tables are trained and the history has advanced.

Top module: `hybrid_bp`

## Requirements
- R1: While reset is asserted and right after it, every component counter holds 01 (weakly not taken), every selector counter holds 01 (weakly bimodal) and the history is zero. As a result lk_taken, lk_bim, lk_gbl and lk_use_gbl are all 0 for any PC.
- R2: The per-address component reads the counter at index lk_pc[ALIGN_W+IDX_W-1:ALIGN_W]. A taken resolve increments the counter at the index taken from rs_pc, and a not-taken resolve decrements it.
- R3: A counter predicts taken exactly when its bit 1 is set. lk_bim and lk_gbl are bit 1 of the addressed counter.
- R4: The global component reads the counter at index (address bits as in R2) XOR history, where history bit 0 is the newest outcome.
- R5: A resolve trains every table using the history as it was before that resolve. The history then becomes {history[IDX_W-2:0], rs_taken}.
- R6: The selector counter is read at (address bits as in R2) XOR the bit-reversed history. When its bit 1 is set, lk_use_gbl is 1 and the global component is chosen.
- R7: The selector is trained only when the two components predicted differently at resolve. It increments when the global component was right and decrements otherwise.
- R8: lk_taken equals lk_gbl when lk_use_gbl is 1 and lk_bim otherwise. Whenever the components agree, lk_taken equals both of them.
- R9: Counters saturate. An increment at 3 leaves 3 and a decrement at 0 leaves 0.
- R10: While rs_valid is 0, rs_pc and rs_taken have no effect. No counter and no history bit changes, so the lookup outputs for a given PC stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_bim | output | 1 | Per-address component direction |
| lk_gbl | output | 1 | Global component direction |
| lk_use_gbl | output | 1 | Selector picks the global component |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The checker watches, on every cycle, the history shift on each resolve and the history holding still between resolves. It also checks that the final direction follows the components whenever they agree, that the lookup outputs cannot move without a resolve, and that the reset state is in place. What the assertions cannot see is the content of the three tables: saturation at both ends, the XOR and reversed-history indexing, and training the selector only on disagreement. The bench shows these through directed scenarios. These include a bimodal counter pushed past both limits, an alternating branch that moves the selector to the global side, an always-taken branch that keeps it bimodal, and a long mixed stream compared against a model built from the requirements.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'b01;

  // saturating step of a 2-bit up/down counter
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

  function automatic logic ctr_dir(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/hbp_rst_sync.sv
`timescale 1ns/1ps
module hbp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/hbp_ctr_table.sv
`timescale 1ns/1ps
module hbp_ctr_table
  import hbp_pkg::*;
#(
  parameter int    IDX_W   = 6,
  parameter ctr2_t RST_VAL = CTR_WEAK_LOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output ctr2_t            lk_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output ctr2_t            up_ctr,
  input  logic             up_en,
  input  logic             up_inc
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cells_q [DEPTH];
  ctr2_t up_nxt;

  assign lk_ctr = cells_q[lk_idx];
  assign up_ctr = cells_q[up_idx];

  always_comb begin
    up_nxt = ctr_step(up_ctr, up_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= RST_VAL;
    end else if (up_en) begin
      cells_q[up_idx] <= up_nxt;
    end
  end
endmodule

// File: rtl/hbp_ghist.sv
`timescale 1ns/1ps
module hbp_ghist #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/hybrid_bp.sv
`timescale 1ns/1ps
module hybrid_bp
  import hbp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_bim,
  output logic            lk_gbl,
  output logic            lk_use_gbl,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  logic              srst_n;
  logic [IDX_W-1:0]  ghist_q;
  logic [IDX_W-1:0]  ghist_rev;

  logic [IDX_W-1:0]  lk_base, rs_base;
  logic [IDX_W-1:0]  lk_g_idx, rs_g_idx;
  logic [IDX_W-1:0]  lk_s_idx, rs_s_idx;

  ctr2_t lk_b_ctr, lk_g_ctr, lk_s_ctr;
  ctr2_t rs_b_ctr, rs_g_ctr, rs_s_ctr;

  logic rs_b_dir, rs_g_dir;
  logic sel_upd_en, sel_upd_inc;

  hbp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // selector hash uses the shared history in reversed bit order
  for (genvar k = 0; k < IDX_W; k++) begin : g_rev
    assign ghist_rev[k] = ghist_q[IDX_W-1-k];
  end

  always_comb begin
    lk_base  = lk_pc[ALIGN_W +: IDX_W];
    rs_base  = rs_pc[ALIGN_W +: IDX_W];
    lk_g_idx = lk_base ^ ghist_q;
    rs_g_idx = rs_base ^ ghist_q;
    lk_s_idx = lk_base ^ ghist_rev;
    rs_s_idx = rs_base ^ ghist_rev;
  end

  hbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_bim (
    .clk    (clk),
    .rst_n  (srst_n),
    .lk_idx (lk_base),
    .lk_ctr (lk_b_ctr),
    .up_idx (rs_base),
    .up_ctr (rs_b_ctr),
    .up_en  (rs_valid),
    .up_inc (rs_taken)
  );

  hbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_gbl (
    .clk    (clk),
    .rst_n  (srst_n),
    .lk_idx (lk_g_idx),
    .lk_ctr (lk_g_ctr),
    .up_idx (rs_g_idx),
    .up_ctr (rs_g_ctr),
    .up_en  (rs_valid),
    .up_inc (rs_taken)
  );

  always_comb begin
    rs_b_dir    = ctr_dir(rs_b_ctr);
    rs_g_dir    = ctr_dir(rs_g_ctr);
    sel_upd_en  = rs_valid && (rs_b_dir != rs_g_dir);
    sel_upd_inc = (rs_g_dir == rs_taken);
  end

  hbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LOW)) u_sel (
    .clk    (clk),
    .rst_n  (srst_n),
    .lk_idx (lk_s_idx),
    .lk_ctr (lk_s_ctr),
    .up_idx (rs_s_idx),
    .up_ctr (rs_s_ctr),
    .up_en  (sel_upd_en),
    .up_inc (sel_upd_inc)
  );

  hbp_ghist #(.HIST_W(IDX_W)) u_hist (
    .clk      (clk),
    .rst_n    (srst_n),
    .shift_en (rs_valid),
    .bit_in   (rs_taken),
    .hist_o   (ghist_q)
  );

  always_comb begin
    lk_bim     = ctr_dir(lk_b_ctr);
    lk_gbl     = ctr_dir(lk_g_ctr);
    lk_use_gbl = ctr_dir(lk_s_ctr);
    lk_taken   = lk_use_gbl ? lk_gbl : lk_bim;
  end

  logic unused_sel_ctr;
  assign unused_sel_ctr = ^rs_s_ctr;
endmodule

// File: rtl/hybrid_bp_chk.sv
`timescale 1ns/1ps
module hybrid_bp_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_taken,
  input logic             lk_bim,
  input logic             lk_gbl,
  input logic             rs_valid,
  input logic             rs_taken,
  input logic [IDX_W-1:0] hist
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (hist == '0 && !lk_taken && !lk_bim && !lk_gbl);
    end
  end

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> (hist == {$past(hist[IDX_W-2:0]), $past(rs_taken)}));

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(hist));

  // R10
  lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> (!$stable(lk_pc) || $stable(lk_taken)));

  // R8
  agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_bim == lk_gbl) |-> (lk_taken == lk_bim));
endmodule

bind hybrid_bp hybrid_bp_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_pc    (lk_pc),
  .lk_taken (lk_taken),
  .lk_bim   (lk_bim),
  .lk_gbl   (lk_gbl),
  .rs_valid (rs_valid),
  .rs_taken (rs_taken),
  .hist     (ghist_q)
);

// File: tb/hybrid_bp_tb.sv
`timescale 1ns/1ps
module hybrid_bp_tb;
  localparam int PC_W    = 32;
  localparam int IDX_W   = 6;
  localparam int ALIGN_W = 2;
  localparam int DEPTH   = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_taken, lk_bim, lk_gbl, lk_use_gbl;
  logic            rs_valid;
  logic [PC_W-1:0] rs_pc;
  logic            rs_taken;

  always #2 clk = ~clk;

  hybrid_bp #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_bim(lk_bim), .lk_gbl(lk_gbl), .lk_use_gbl(lk_use_gbl),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [1:0]       m_bim [DEPTH];
  logic [1:0]       m_gbl [DEPTH];
  logic [1:0]       m_sel [DEPTH];
  logic [IDX_W-1:0] m_hist;

  function automatic logic [IDX_W-1:0] f_base(input logic [PC_W-1:0] pc);
    return pc[ALIGN_W +: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_rev(input logic [IDX_W-1:0] h);
    logic [IDX_W-1:0] r;
    for (int k = 0; k < IDX_W; k++) r[k] = h[IDX_W-1-k];
    return r;
  endfunction

  function automatic logic [1:0] f_sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_bim[i] = 2'b01; m_gbl[i] = 2'b01; m_sel[i] = 2'b01;
    end
    m_hist = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; lk_pc = '0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // look up a PC and compare all four outputs against the model
  task automatic probe(input logic [PC_W-1:0] pc, input string req);
    logic b, g, s;
    @(negedge clk);
    lk_pc = pc;
    #1;
    b = m_bim[f_base(pc)][1];
    g = m_gbl[f_base(pc) ^ m_hist][1];
    s = m_sel[f_base(pc) ^ f_rev(m_hist)][1];
    chk(req, "lk_bim", lk_bim, b);
    chk(req, "lk_gbl", lk_gbl, g);
    chk(req, "lk_use_gbl", lk_use_gbl, s);
    chk(req, "lk_taken", lk_taken, s ? g : b);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic tk);
    logic [IDX_W-1:0] bi, gi, si;
    logic bd, gd;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk;
    @(posedge clk);
    bi = f_base(pc); gi = bi ^ m_hist; si = bi ^ f_rev(m_hist);
    bd = m_bim[bi][1]; gd = m_gbl[gi][1];
    m_bim[bi] = f_sat(m_bim[bi], tk);
    m_gbl[gi] = f_sat(m_gbl[gi], tk);
    if (bd != gd) m_sel[si] = f_sat(m_sel[si], gd == tk);
    m_hist = {m_hist[IDX_W-2:0], tk};
    #1;
    rs_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      probe(32'h0000_1000 + 32'(i * 52), "R1");
      chk("R1", "lk_taken after reset", lk_taken, 1'b0);
    end
  endtask

  task automatic t_bim_limits();
    logic [PC_W-1:0] pc = 32'h0000_0040;
    do_reset();
    resolve(pc, 1'b1); probe(pc, "R2");
    chk("R2", "bim after one taken", lk_bim, 1'b1);
    repeat (3) resolve(pc, 1'b1);
    resolve(pc, 1'b0); probe(pc, "R9");
    chk("R9", "bim held at top then one down", lk_bim, 1'b1);
    resolve(pc, 1'b0); probe(pc, "R3");
    chk("R3", "bim counter 1 predicts not taken", lk_bim, 1'b0);
    repeat (4) resolve(pc, 1'b0);
    resolve(pc, 1'b1); probe(pc, "R9");
    chk("R9", "bim held at floor then one up", lk_bim, 1'b0);
    resolve(pc, 1'b1); probe(pc, "R2");
    chk("R2", "bim reaches 2", lk_bim, 1'b1);
  endtask

  task automatic t_history();
    do_reset();
    for (int i = 0; i < 24; i++) begin
      logic [PC_W-1:0] pc = 32'h0000_0200 + 32'((i % 3) * 4);
      resolve(pc, (i % 4) != 1);
      probe(pc, "R4");
      probe(pc + 32'h10, "R5");
    end
  endtask

  task automatic t_sel_to_global();
    logic [PC_W-1:0] pc = 32'h0000_0300;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      resolve(pc, i[0] == 1'b0);
      probe(pc, "R6");
    end
    chk("R7", "selector moved to global", lk_use_gbl, 1'b1);
    chk("R6", "alternation predicted taken next", lk_taken, 1'b1);
  endtask

  task automatic t_sel_stays_bim();
    logic [PC_W-1:0] pc = 32'h0000_0084;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      resolve(pc, 1'b1);
      probe(pc, "R7");
    end
    chk("R7", "selector stays bimodal", lk_use_gbl, 1'b0);
    chk("R8", "final follows bimodal", lk_taken, 1'b1);
  endtask

  task automatic t_ignore();
    logic b0, g0, t0;
    do_reset();
    for (int i = 0; i < 6; i++) resolve(32'h0000_0500 + 32'(i * 4), i[0]);
    probe(32'h0000_0500, "R10");
    b0 = lk_bim; g0 = lk_gbl; t0 = lk_taken;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      rs_pc = 32'h0000_0500 + 32'(i * 4);
      rs_taken = ~i[0];
    end
    probe(32'h0000_0500, "R10");
    chk("R10", "lk_bim unchanged", lk_bim, b0);
    chk("R10", "lk_gbl unchanged", lk_gbl, g0);
    chk("R10", "lk_taken unchanged", lk_taken, t0);
  endtask

  task automatic t_mix();
    logic [31:0] lcg = 32'h1234_5678;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [PC_W-1:0] pc;
      logic tk;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pc = 32'h0000_0800 + {27'd0, lcg[18:16], 2'b00};
      case (lcg[18:16])
        3'd0, 3'd1: tk = 1'b1;
        3'd2:       tk = 1'b0;
        3'd3:       tk = m_hist[0];
        3'd4:       tk = ~m_hist[1];
        default:    tk = lcg[27];
      endcase
      probe(pc, "R8");
      resolve(pc, tk);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; lk_pc = '0;
    model_reset();
    t_reset();
    t_bim_limits();
    t_history();
    t_sel_to_global();
    t_sel_stays_bim();
    t_ignore();
    t_mix();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule